// File: doc/BRIEF.md
# Iterative Karatsuba Carry-Less Multiplier

This block multiplies two 256-bit polynomials over GF(2) and returns the unreduced 511-bit product. Polynomial multiplication over GF(2) is a carry-less multiply: partial products are combined with XOR instead of addition. The block is built for a binary-field arithmetic unit, and reduction modulo the field polynomial is left to a later stage. The design uses a single 64x64 combinational carry-less multiplier. It reuses that multiplier over nine consecutive clock cycles, following a two-level Karatsuba schedule on four 64-bit segments of each operand.

Each cycle, a sequencer index from 0 to 8 picks one segment pair:

| Index | Segment pair |
|-------|--------------|
| 0 | a0·b0 |
| 1 | a1·b1 |
| 2 | a2·b2 |
| 3 | a3·b3 |
| 4 | (a0+a1)·(b0+b1) |
| 5 | (a0+a2)·(b0+b2) |
| 6 | (a1+a3)·(b1+b3) |
| 7 | (a2+a3)·(b2+b3) |
| 8 | (a0+a1+a2+a3)·(b0+b1+b2+b3) |

The selection logic XORs the named segments together to form each operand. The 127-bit partial product is then XORed into a result register at every 64-bit offset where it contributes to the final product. After the ninth step, the register holds the exact product.

Software or a sequencer drives the block as follows. It presents both operands and pulses `start` while the block is idle. It then waits for the single-cycle `done` pulse and reads `product`, which stays fixed until the next accepted start.

Top module: `gf2_iter_mult`

## Requirements
- R1: After reset, `busy` and `done` are 0 and `product` is all zeros.
- R2: When `start` is 1 while `busy` is 0, the block captures `op_a` and `op_b`. In the next cycle `busy` is 1 and `product` reads all zeros.
- R3: `busy` stays 1 for exactly nine consecutive cycles. In the cycle after the last of them, `busy` is 0 and `done` is 1 for that one cycle only.
- R4: While `done` is 1, `product` equals the carry-less product of the captured operands, with bit i of the result being the XOR of a[j]&b[i-j] over all valid j.
- R5: Changes on `op_a` and `op_b` while `busy` is 1 have no effect on the result.
- R6: A `start` pulse while `busy` is 1 is ignored. The running multiplication keeps its operands and its nine-cycle timing.
- R7: While `busy` is 0 and no start is accepted, `product` holds its value.
- R8: A `start` present in the cycle where `done` is 1 is accepted, so multiplications can run back to back with one idle-looking cycle between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a multiplication when idle |
| op_a | input | 256 | First polynomial operand, bit i is the x^i coefficient |
| op_b | input | 256 | Second polynomial operand |
| busy | output | 1 | A multiplication is in progress |
| done | output | 1 | One-cycle pulse: product is complete |
| product | output | 511 | Unreduced carry-less product |

## Verification
Several internal faults show up only as a wrong product word at the `done` pulse, nine cycles after the start that caused them:
- a wrong offset mask, which misplaces a partial product;
- a wrong segment-select mask;
- an off-by-one sequencer index.

Operands that light a single segment, or only the top coefficient, make each offset and each segment sum visible on its own. A sequencer fault that stretches or shortens the run moves `busy` and `done` away from the expected cycle at once. A capture fault only appears when the operand pins change during the run, so the stimulus changes them while the block is busy.

// File: rtl/gfm_pkg.sv
package gfm_pkg;

    localparam int NUM_SEG   = 4;
    localparam int NUM_PAIRS = 9;
    localparam int NUM_OFF   = 2 * NUM_SEG - 1;
    localparam int IDX_W     = $clog2(NUM_PAIRS);

    typedef logic [IDX_W-1:0]   step_t;
    typedef logic [NUM_SEG-1:0] seg_mask_t;
    typedef logic [NUM_OFF-1:0] off_mask_t;

    localparam step_t LAST_STEP = step_t'(NUM_PAIRS - 1);

    // Which operand segments are XOR-summed to form the operands of each step.
    function automatic seg_mask_t step_segments(input step_t idx);
        case (idx)
            4'd0:    return 4'b0001;
            4'd1:    return 4'b0010;
            4'd2:    return 4'b0100;
            4'd3:    return 4'b1000;
            4'd4:    return 4'b0011;
            4'd5:    return 4'b0101;
            4'd6:    return 4'b1010;
            4'd7:    return 4'b1100;
            4'd8:    return 4'b1111;
            default: return 4'b0000;
        endcase
    endfunction

    // Bit k set: this step's partial product is XORed in at offset k segments.
    // Derived from two nested Karatsuba recombinations.
    function automatic off_mask_t step_offsets(input step_t idx);
        case (idx)
            4'd0:    return 7'h0F;
            4'd1:    return 7'h1E;
            4'd2:    return 7'h3C;
            4'd3:    return 7'h78;
            4'd4:    return 7'h0A;
            4'd5:    return 7'h0C;
            4'd6:    return 7'h18;
            4'd7:    return 7'h28;
            4'd8:    return 7'h08;
            default: return 7'h00;
        endcase
    endfunction

endpackage

// File: rtl/gfm_seg_select.sv
module gfm_seg_select
    import gfm_pkg::*;
#(
    parameter int SEG_W = 64
) (
    input  logic [NUM_SEG*SEG_W-1:0] word,
    input  seg_mask_t                pick,
    output logic [SEG_W-1:0]         seg_sum
);

    always_comb begin
        seg_sum = '0;
        for (int s = 0; s < NUM_SEG; s++) begin
            if (pick[s]) begin
                seg_sum = seg_sum ^ word[s*SEG_W +: SEG_W];
            end
        end
    end

endmodule

// File: rtl/gfm_clmul.sv
module gfm_clmul #(
    parameter int W = 64
) (
    input  logic [W-1:0]   x,
    input  logic [W-1:0]   y,
    output logic [2*W-2:0] z
);

    localparam int ZW = 2 * W - 1;

    logic [ZW-1:0] rows [W];

    for (genvar i = 0; i < W; i++) begin : g_row
        assign rows[i] = y[i] ? (ZW'(x) << i) : '0;
    end

    always_comb begin
        z = '0;
        for (int i = 0; i < W; i++) begin
            z = z ^ rows[i];
        end
    end

endmodule

// File: rtl/gfm_accum.sv
module gfm_accum
    import gfm_pkg::*;
#(
    parameter int SEG_W = 64
) (
    input  logic [2*SEG_W-2:0]           part,
    input  off_mask_t                    place,
    input  logic [2*NUM_SEG*SEG_W-2:0]   acc_in,
    output logic [2*NUM_SEG*SEG_W-2:0]   acc_out
);

    localparam int RES_W = 2 * NUM_SEG * SEG_W - 1;

    logic [RES_W-1:0] terms [NUM_OFF];

    for (genvar k = 0; k < NUM_OFF; k++) begin : g_off
        localparam int SHIFT = k * SEG_W;
        assign terms[k] = place[k] ? (RES_W'(part) << SHIFT) : '0;
    end

    always_comb begin
        acc_out = acc_in;
        for (int k = 0; k < NUM_OFF; k++) begin
            acc_out = acc_out ^ terms[k];
        end
    end

endmodule

// File: rtl/gf2_iter_mult.sv
module gf2_iter_mult
    import gfm_pkg::*;
#(
    parameter int SEG_W = 64
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start,
    input  logic [NUM_SEG*SEG_W-1:0]      op_a,
    input  logic [NUM_SEG*SEG_W-1:0]      op_b,
    output logic                          busy,
    output logic                          done,
    output logic [2*NUM_SEG*SEG_W-2:0]    product
);

    localparam int OP_W  = NUM_SEG * SEG_W;
    localparam int PP_W  = 2 * SEG_W - 1;
    localparam int RES_W = 2 * OP_W - 1;

    typedef struct packed {
        logic             busy;
        logic             done;
        step_t            idx;
        logic [OP_W-1:0]  a;
        logic [OP_W-1:0]  b;
        logic [RES_W-1:0] acc;
    } state_t;

    state_t st_d, st_q;

    logic [SEG_W-1:0] sel_a, sel_b;
    logic [PP_W-1:0]  part;
    logic [RES_W-1:0] acc_next;
    seg_mask_t        pick;
    off_mask_t        place;

    assign pick  = step_segments(st_q.idx);
    assign place = step_offsets(st_q.idx);

    gfm_seg_select #(.SEG_W(SEG_W)) u_sel_a (
        .word    (st_q.a),
        .pick    (pick),
        .seg_sum (sel_a)
    );

    gfm_seg_select #(.SEG_W(SEG_W)) u_sel_b (
        .word    (st_q.b),
        .pick    (pick),
        .seg_sum (sel_b)
    );

    gfm_clmul #(.W(SEG_W)) u_core (
        .x (sel_a),
        .y (sel_b),
        .z (part)
    );

    gfm_accum #(.SEG_W(SEG_W)) u_accum (
        .part    (part),
        .place   (place),
        .acc_in  (st_q.acc),
        .acc_out (acc_next)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!st_q.busy) begin
            if (start) begin
                st_d.busy = 1'b1;
                st_d.idx  = '0;
                st_d.a    = op_a;
                st_d.b    = op_b;
                st_d.acc  = '0;
            end
        end else begin
            st_d.acc = acc_next;
            if (st_q.idx == LAST_STEP) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
                st_d.idx  = '0;
            end else begin
                st_d.idx = step_t'(st_q.idx + step_t'(1));
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy    = st_q.busy;
    assign done    = st_q.done;
    assign product = st_q.acc;

endmodule

// File: rtl/gfm_checks.sv
module gfm_checks #(
    parameter int RES_W = 511
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic [RES_W-1:0] product
);

    logic [3:0] run_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_len <= '0;
        end else if (busy) begin
            run_len <= run_len + 4'd1;
        end else if (start) begin
            run_len <= '0;
        end
    end

    // R3: done lasts a single cycle
    a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R3: done follows the last busy cycle, with busy already low
    a_r3_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    // R3: exactly nine busy cycles precede done
    a_r3_nine_steps: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (run_len == 4'd9));

    // R3, R6: a run never exceeds nine cycles
    a_r6_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (run_len < 4'd9));

    // R2: busy rises only after a start
    a_r2_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    // R2: the result register is cleared at the beginning of a run
    a_r2_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (product == '0));

    // R7: idle without start keeps the product
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(product));

endmodule

bind gf2_iter_mult gfm_checks #(.RES_W(RES_W)) u_checks (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .product (product)
);

// File: tb/test_gf2_iter_mult.sv
module test_gf2_iter_mult;

    localparam int OPW = 256;
    localparam int RW  = 511;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic [OPW-1:0] op_a = '0;
    logic [OPW-1:0] op_b = '0;
    logic           busy, done;
    logic [RW-1:0]  product;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    gf2_iter_mult i_gf2_iter_mult (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .op_a    (op_a),
        .op_b    (op_b),
        .busy    (busy),
        .done    (done),
        .product (product)
    );

    function automatic logic [RW-1:0] ref_mul(input logic [OPW-1:0] a, input logic [OPW-1:0] b);
        logic [RW-1:0] r = '0;
        for (int i = 0; i < OPW; i++) begin
            if (b[i]) r = r ^ (RW'(a) << i);
        end
        return r;
    endfunction

    function automatic logic [OPW-1:0] rnd256();
        logic [OPW-1:0] v;
        for (int i = 0; i < 8; i++) v[i*32 +: 32] = $urandom;
        return v;
    endfunction

    task automatic chk(input string tag, input logic [RW-1:0] act, input logic [RW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Behavioural model, advanced on every rising edge
    logic          m_busy, m_done;
    int            m_cnt;
    logic [RW-1:0] m_prod, m_ref;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_busy <= 1'b0; m_done <= 1'b0; m_cnt <= 0; m_prod <= '0; m_ref <= '0;
        end else begin
            m_done <= 1'b0;
            if (!m_busy) begin
                if (start) begin
                    m_busy <= 1'b1; m_cnt <= 0; m_prod <= '0;
                    m_ref  <= ref_mul(op_a, op_b);
                end
            end else if (m_cnt == 8) begin
                m_busy <= 1'b0; m_done <= 1'b1; m_prod <= m_ref; m_cnt <= 0;
            end else begin
                m_cnt <= m_cnt + 1;
            end
        end
    end

    // Compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R3 busy", RW'(busy), RW'(m_busy));
            chk("R3 done", RW'(done), RW'(m_done));
            if (m_done)                    chk("R4 product at done", product, m_prod);
            else if (!m_busy)              chk("R7 product held", product, m_prod);
            else if (m_cnt == 0)           chk("R2 product cleared", product, '0);
        end
    end

    task automatic drive(input logic s, input logic [OPW-1:0] a, input logic [OPW-1:0] b);
        @(posedge clk); #2;
        start = s; op_a = a; op_b = b;
    endtask

    task automatic wait_done();
        int guard = 0;
        do begin
            @(negedge clk);
            guard++;
        end while (!done && guard < 40);
    endtask

    task automatic run_mul(input logic [OPW-1:0] a, input logic [OPW-1:0] b);
        drive(1'b1, a, b);
        drive(1'b0, a, b);
        wait_done();
        chk("R4 direct", product, ref_mul(a, b));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [OPW-1:0] a0, b0;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        chk("R1 busy", RW'(busy), '0);
        chk("R1 done", RW'(done), '0);
        chk("R1 product", product, '0);

        // R2: busy rises one cycle after start
        drive(1'b1, 256'h3, 256'h5);
        drive(1'b0, '0, '0);
        @(negedge clk);
        chk("R2 busy high", RW'(busy), RW'(1'b1));
        wait_done();
        chk("R4 small", product, RW'(15));

        // Corner operands
        run_mul('0, rnd256());
        run_mul('1, '1);
        run_mul(256'h1, 256'h1);
        run_mul({1'b1, 255'b0}, {1'b1, 255'b0});
        for (int s = 0; s < 4; s++) begin
            for (int t = 0; t < 4; t++) begin
                run_mul(OPW'({64{1'b1}}) << (64*s), rnd256() & (OPW'({64{1'b1}}) << (64*t)));
            end
        end
        for (int n = 0; n < 20; n++) run_mul(rnd256(), rnd256());

        // R5: operand pins change every cycle during the run
        a0 = rnd256(); b0 = rnd256();
        drive(1'b1, a0, b0);
        for (int k = 0; k < 9; k++) drive(1'b0, rnd256(), rnd256());
        wait_done();
        chk("R5 latched operands", product, ref_mul(a0, b0));

        // R6: start pulses while busy are ignored
        a0 = rnd256(); b0 = rnd256();
        drive(1'b1, a0, b0);
        drive(1'b0, a0, b0);
        drive(1'b1, rnd256(), rnd256());
        drive(1'b0, a0, b0);
        drive(1'b1, rnd256(), rnd256());
        drive(1'b0, a0, b0);
        wait_done();
        chk("R6 ignored start", product, ref_mul(a0, b0));

        // R8: start present in the done cycle begins the next run
        a0 = rnd256(); b0 = rnd256();
        drive(1'b1, rnd256(), rnd256());
        drive(1'b0, a0, b0);
        wait_done();
        #3 start = 1'b1;
        @(posedge clk); #2 start = 1'b0;
        @(negedge clk);
        chk("R8 back-to-back busy", RW'(busy), RW'(1'b1));
        wait_done();
        chk("R8 second product", product, ref_mul(a0, b0));

        // R7: idle with changing operands and no start
        for (int k = 0; k < 6; k++) drive(1'b0, rnd256(), rnd256());
        @(negedge clk);
        chk("R7 idle product", product, ref_mul(a0, b0));

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule